// File: doc/BRIEF.md
# Word-Wide EPROM Device Model with Mode Decoding and Identifier Readout

This block is a clocked, synthesizable stand-in for a 16-bit-wide ultraviolet-erasable read-only memory. It is meant for chip-level benches and FPGA emulation boards that must present such a memory to a host. The chip enable, output enable and program strobe pins arrive as ordinary active-low logic. The analog conditions arrive as two plain flags: programming voltage present, and high voltage on address line 9. From these inputs the block picks one of seven operating modes. That mode decides whether the array is read, written or left alone, and whether the data bus is driven.

Storage is a parameterized array that reads as all ones after reset. A program operation can only turn ones into zeros. A dedicated identification mode returns a fixed manufacturer byte or a fixed device byte, chosen by address bit 0. That mode also checks that the other address bits are low. Every output is registered, so the result for the inputs seen at one rising edge appears just after that edge. The decoded mode is also brought out on a small debug bus.

Top module: `eprom_mode_model`

## Requirements
- R1: With ce_n=0, oe_n=0, vpp_hi=0 and a9_hv=0, the stored word at addr appears on dout after the next rising edge, with dout_en=1 and mode=3'd1 (read).
- R2: With ce_n=1 and vpp_hi=0, the block is in standby (mode=3'd0) with dout_en=0, for either value of oe_n.
- R3: With ce_n=0 and oe_n=1, and no program operation selected, dout_en=0 and mode=3'd2 (output off). This covers vpp_hi=0, and vpp_hi=1 with pgm_n=1.
- R4: With ce_n=0, pgm_n=0 and vpp_hi=1, the word at addr becomes (old word AND din) at the rising edge. In this case mode=3'd3 and dout_en=0, whatever oe_n is.
- R5: With ce_n=0, oe_n=0, pgm_n=1 and vpp_hi=1, the stored word is driven with dout_en=1 and mode=3'd4 (verify).
- R6: With ce_n=1 and vpp_hi=1, the block is inhibited (mode=3'd5) with dout_en=0, and the array is not written even when pgm_n=0.
- R7: With ce_n=0, oe_n=0, vpp_hi=0 and a9_hv=1, and every address bit other than bits 0 and 9 low, mode=3'd6 and dout_en=1. dout reads 16'h0001 when addr[0]=0 and 16'h0098 when addr[0]=1. The upper byte is zero, and the low byte always has odd parity.
- R8: In the identification mode, if any address bit other than bits 0 and 9 is set, id_err=1 and dout_en=0. In every other case id_err=0.
- R9: After reset every word reads 16'hFFFF. A later program with ones in din never sets a bit that an earlier program cleared.
- R10: While rst_n=0 at a rising edge, the outputs after that edge are dout=0, dout_en=0, id_err=0 and mode=3'd0.
- R11: Whenever dout_en=0, dout is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming voltage present |
| a9_hv | input | 1 | High voltage present on address line 9 |
| addr | input | ADDR_W (10) | Word address |
| din | input | DATA_W (16) | Word to program |
| dout | output | DATA_W (16) | Read, verify or identifier data; zero when not driven |
| dout_en | output | 1 | Data bus is driven |
| id_err | output | 1 | Identification requested with a stray address bit set |
| mode | output | 3 | Decoded operating mode, registered |

## Verification
A single program pulse does two things to a word in the same write. It clears the new zero bits of din, and it keeps the bits that earlier pulses already cleared. The bench provokes this by programming one word with a pattern, then again with all ones, then with a pattern that overlaps the first. A verify read follows each step. Each result is judged against the AND of all data programmed into that word so far.

// File: rtl/eprom_pkg.sv
// Package: shared mode encoding, identifier constants and helpers for the
// EPROM device model. Assumes identifier bytes sit in the low byte of the bus.
package eprom_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_READ    = 3'd1,
        MODE_OUTOFF  = 3'd2,
        MODE_PROGRAM = 3'd3,
        MODE_VERIFY  = 3'd4,
        MODE_INHIBIT = 3'd5,
        MODE_IDENT   = 3'd6
    } eprom_mode_e;

    localparam logic [7:0] MFR_ID_BYTE = 8'h01;
    localparam logic [7:0] DEV_ID_BYTE = 8'h98;

    // Odd-parity test of one byte: true when the count of ones is odd.
    function automatic logic odd_parity(input logic [7:0] b);
        return ^b;
    endfunction

    // True when the decoded mode places data on the bus.
    function automatic logic mode_drives(input eprom_mode_e m);
        return (m == MODE_READ) || (m == MODE_VERIFY) || (m == MODE_IDENT);
    endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
// Module: eprom_mode_decode
// Turns the control pins and the two voltage flags into one operating mode.
// Assumes: purely combinational; the programming voltage takes precedence
// over the address-9 high-voltage flag, so identification needs vpp_hi=0.
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        pgm_n,
    input  logic        vpp_hi,
    input  logic        a9_hv,
    output eprom_mode_e mode
);

    // Priority decode: chip select first, then programming, then reads.
    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? MODE_INHIBIT : MODE_STANDBY;
        end else if (vpp_hi) begin
            if (!pgm_n)
                mode = MODE_PROGRAM;
            else if (!oe_n)
                mode = MODE_VERIFY;
            else
                mode = MODE_OUTOFF;
        end else if (oe_n) begin
            mode = MODE_OUTOFF;
        end else if (a9_hv) begin
            mode = MODE_IDENT;
        end else begin
            mode = MODE_READ;
        end
    end

endmodule

// File: rtl/eprom_id_unit.sv
// Module: eprom_id_unit
// Produces the identifier word for the identification mode, and flags an
// address that has a stray bit set outside bits 0 and 9.
// Assumes: DATA_W >= 8; identifier bytes are placed in the low byte.
module eprom_id_unit
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] id_word,
    output logic              id_bad
);

    // Mask of address bits that must be low during identification.
    function automatic logic [ADDR_W-1:0] strict_mask();
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++)
            m[i] = !((i == 0) || (i == 9));
        return m;
    endfunction

    localparam logic [ADDR_W-1:0] STRICT_MASK = strict_mask();

    // Pick the identifier byte by address bit 0 and zero-extend it.
    always_comb begin
        id_word      = '0;
        id_word[7:0] = addr[0] ? DEV_ID_BYTE : MFR_ID_BYTE;
    end

    // Any stray address bit invalidates the identification request.
    always_comb begin
        id_bad = |(addr & STRICT_MASK);
    end

endmodule

// File: rtl/eprom_array.sv
// Module: eprom_array
// Word storage with an erased state of all ones. A per-word "touched" bit
// stands in for the erase: untouched words read as ones, so reset costs
// one cycle. Writes merge with AND, so bits can only be cleared.
// Assumes: the read is combinational; the write lands at the rising edge;
// addresses at or above DEPTH read as ones and ignore writes.
module eprom_array #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W + 1)'(DEPTH);

    logic [DATA_W-1:0] cells   [DEPTH];
    logic [DEPTH-1:0]  touched;
    logic              in_range;

    // Decide whether the address falls inside the array.
    always_comb begin
        in_range = ({1'b0, addr} < DEPTH_L);
    end

    // Read: an untouched or out-of-range word shows the erased pattern.
    always_comb begin
        if (in_range && touched[addr])
            rd_data = cells[addr];
        else
            rd_data = '1;
    end

    // Track which words hold programmed data; reset returns all to erased.
    always_ff @(posedge clk) begin
        if (!rst_n)
            touched <= '0;
        else if (wr_en && in_range)
            touched[addr] <= 1'b1;
    end

    // Store the AND of the old word and the new data.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en && in_range)
            cells[addr] <= rd_data & wr_data;
    end

endmodule

// File: rtl/eprom_mode_model.sv
// Module: eprom_mode_model (top)
// Device-side EPROM model: decodes the mode, programs the array, and
// registers the data bus, the drive indication, the identifier error and
// the debug mode.
// Assumes: all outputs reflect the inputs sampled at the previous rising
// edge; high impedance is shown as dout_en=0 with dout forced to zero.
module eprom_mode_model
    import eprom_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              id_err,
    output logic [2:0]        mode
);

    eprom_mode_e       cur_mode;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] id_word;
    logic              id_bad;
    logic              wr_en;

    eprom_mode_decode u_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .a9_hv  (a9_hv),
        .mode   (cur_mode)
    );

    eprom_id_unit #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_id (
        .addr    (addr),
        .id_word (id_word),
        .id_bad  (id_bad)
    );

    // Program pulses write only while out of reset and in program mode.
    always_comb begin
        wr_en = rst_n && (cur_mode == MODE_PROGRAM);
    end

    eprom_array #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (din),
        .rd_data (arr_rd)
    );

    // Register the bus contents, drive flag and error flag for this mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
            id_err  <= 1'b0;
        end else begin
            dout    <= '0;
            dout_en <= 1'b0;
            id_err  <= 1'b0;
            case (cur_mode)
                MODE_READ, MODE_VERIFY: begin
                    dout    <= arr_rd;
                    dout_en <= 1'b1;
                end
                MODE_IDENT: begin
                    if (id_bad) begin
                        id_err <= 1'b1;
                    end else begin
                        dout    <= id_word;
                        dout_en <= mode_drives(cur_mode);
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the decoded mode for the debug output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_STANDBY;
        else
            mode <= cur_mode;
    end

endmodule

// File: rtl/eprom_mode_sva.sv
// Module: eprom_mode_sva
// Checker bound to eprom_mode_model; relates the sampled pins to the
// registered outputs one cycle later.
module eprom_mode_sva #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              id_err,
    input logic [2:0]        mode
);

    logic pv;

    // Set once a rising edge has been seen with reset released.
    always_ff @(posedge clk) begin
        pv <= rst_n;
    end

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(!ce_n && !oe_n && !vpp_hi && !a9_hv) |-> dout_en && mode == 3'd1); // R1

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(ce_n && !vpp_hi) |-> !dout_en && mode == 3'd0); // R2

    AST_PROGRAM_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(!ce_n && !pgm_n && vpp_hi) |-> !dout_en && mode == 3'd3); // R4

    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(ce_n && vpp_hi) |-> !dout_en && mode == 3'd5); // R6

    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en && mode == 3'd6 |-> (^dout[7:0]) && dout[DATA_W-1:8] == '0); // R7

    AST_ID_ERR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |-> !dout_en && mode == 3'd6); // R8

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0); // R11

endmodule

bind eprom_mode_model eprom_mode_sva #(.DATA_W(DATA_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hi  (vpp_hi),
    .a9_hv   (a9_hv),
    .dout    (dout),
    .dout_en (dout_en),
    .id_err  (id_err),
    .mode    (mode)
);

// File: tb/tb_eprom_mode_model.sv
// Scoreboard bench: the driver applies one input set per cycle and queues
// the expected registered outputs; the monitor compares after each edge.
module tb_eprom_mode_model;

    localparam int DEPTH  = 1024;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic              vpp_hi = 1'b0, a9_hv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_en, id_err;
    logic [2:0]        mode;

    typedef struct {
        logic [15:0] d;
        logic        en;
        logic        err;
        logic [2:0]  m;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] ref_mem [int];
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #5 clk = ~clk;

    eprom_mode_model #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .id_err(id_err), .mode(mode)
    );

    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 16'hFFFF;
    endfunction

    // Driver: apply one cycle of stimulus and queue its expected outputs.
    task automatic step(input logic r, input logic ce, input logic oe,
                        input logic pg, input logic vp, input logic hv,
                        input int a, input logic [15:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = r; ce_n = ce; oe_n = oe; pgm_n = pg; vpp_hi = vp; a9_hv = hv;
        addr = ADDR_W'(a); din = d;
        e.d = 16'h0; e.en = 1'b0; e.err = 1'b0; e.m = 3'd0; e.tag = tag;
        if (!r) begin
            ref_mem.delete();                                   // R10, R9
        end else if (ce) begin
            e.m = vp ? 3'd5 : 3'd0;                             // R6, R2
        end else if (vp && !pg) begin
            e.m = 3'd3;                                         // R4
            ref_mem[a] = ref_rd(a) & d;
        end else if (oe) begin
            e.m = 3'd2;                                         // R3
        end else if (vp) begin
            e.m = 3'd4; e.en = 1'b1; e.d = ref_rd(a);           // R5
        end else if (hv) begin
            e.m = 3'd6;                                         // R7, R8
            if ((a & ~32'h201) != 0) e.err = 1'b1;
            else begin e.en = 1'b1; e.d = (a & 1) ? 16'h0098 : 16'h0001; end
        end else begin
            e.m = 3'd1; e.en = 1'b1; e.d = ref_rd(a);           // R1
        end
        sb_q.push_back(e);
    endtask

    // Monitor: after each edge, pop the oldest expectation and compare.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (dout !== e.d || dout_en !== e.en || id_err !== e.err || mode !== e.m) begin
                    n_fail++;
                    $display("FAIL %s: got dout=%h en=%b err=%b mode=%0d exp dout=%h en=%b err=%b mode=%0d",
                             e.tag, dout, dout_en, id_err, mode, e.d, e.en, e.err, e.m);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        step(0, 1, 1, 1, 0, 0, 0, 16'h0, "R10 reset");
        step(0, 0, 0, 1, 0, 0, 5, 16'h0, "R10 reset with read pins");
        // R9 + R1: erased word reads all ones
        step(1, 0, 0, 1, 0, 0, 5, 16'h0, "R1 R9 erased read");
        // R2: standby ignores oe_n
        step(1, 1, 0, 1, 0, 0, 5, 16'h0, "R2 standby oe low");
        step(1, 1, 1, 1, 0, 0, 5, 16'h0, "R2 standby oe high");
        // R3: output off
        step(1, 0, 1, 1, 0, 0, 5, 16'h0, "R3 output off");
        // R4: program with oe_n low still does not drive
        step(1, 0, 0, 0, 1, 0, 5, 16'h12F0, "R4 program");
        step(1, 0, 0, 1, 1, 0, 5, 16'h0, "R5 verify");
        // R9: ones cannot restore cleared bits; overlap clears more
        step(1, 0, 1, 0, 1, 0, 5, 16'hFFFF, "R9 program ones");
        step(1, 0, 0, 1, 1, 0, 5, 16'h0, "R9 verify kept");
        step(1, 0, 1, 0, 1, 0, 5, 16'h0F0F, "R4 program overlap");
        step(1, 0, 0, 1, 1, 0, 5, 16'h0, "R9 verify 0200");
        step(1, 0, 0, 1, 0, 0, 5, 16'h0, "R1 read programmed");
        // R3: verify conditions with oe_n high
        step(1, 0, 1, 1, 1, 0, 5, 16'h0, "R3 vpp oe high");
        // R6: inhibited program does not write
        step(1, 1, 0, 0, 1, 0, 7, 16'h0000, "R6 inhibit");
        step(1, 0, 0, 1, 0, 0, 7, 16'h0, "R6 readback erased");
        // R7: identifiers
        step(1, 0, 0, 1, 0, 1, 0, 16'h0, "R7 mfr id");
        step(1, 0, 0, 1, 0, 1, 1, 16'h0, "R7 dev id");
        step(1, 0, 0, 1, 0, 1, 32'h201, 16'h0, "R7 dev id a9 set");
        // R8: stray address bits
        step(1, 0, 0, 1, 0, 1, 4, 16'h0, "R8 stray bit 2");
        step(1, 0, 0, 1, 0, 1, 32'h301, 16'h0, "R8 stray bit 8");
        // R11 via idle after error; then top word program/read
        step(1, 0, 1, 1, 0, 1, 0, 16'h0, "R11 ident oe high");
        step(1, 0, 0, 0, 1, 0, DEPTH - 1, 16'hA5A5, "R4 program top word");
        step(1, 0, 0, 1, 0, 0, DEPTH - 1, 16'h0, "R1 read top word");
        // R9 + R10: reset returns array to erased
        step(0, 1, 1, 1, 0, 0, 0, 16'h0, "R10 second reset");
        step(1, 0, 0, 1, 0, 0, 5, 16'h0, "R9 erased after reset");
        step(1, 1, 1, 1, 0, 0, 0, 16'h0, "R2 final standby");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule